// File: doc/BRIEF.md
# Tunable Capacitor Serial Control Slave

This block receives a write-only three-wire serial word that selects a 5-bit capacitance tuning code and a standby control. The master raises an enable line, clocks bits in most significant bit first on rising edges of a serial clock, and then drops the enable. The falling enable transfers the received word into the active register that drives the tuning code and the standby output. Until that transfer, the outputs keep their previous values.

The receiver does not count bits. It keeps a sliding 8-bit window of the latest bits received. If more than 8 bits arrive, only the last 8 remain in the window. If fewer arrive, the upper positions still hold older bits. The two most significant bits of a word are reserved and must be zero. A committed word that breaks this rule sets a sticky error flag, and the standby bit and the tuning field still take effect.

All three serial lines are oversampled by a fast system clock. Each line passes through a synchronizer and then an edge detector, so the system clock must run at least four times faster than the serial clock.

Top module: `tunecap_serial_slave`

## Requirements
- R1: After reset the tuning code is 00000, standby is 0 and the error flag is 0. The capture window is cleared to zero.
- R2: While the enable is high, each rising serial clock edge shifts the data line into the window, most significant bit first. After commit, word bits 4..0 appear on the tuning code, from 00000 (minimum) to 11111 (maximum).
- R3: The outputs keep their previous values while a word is being clocked in, and change only after the enable falls.
- R4: When more than 8 bits are clocked in one enable window, only the last 8 received are committed.
- R5: When fewer than 8 bits are clocked, the commit uses the shifted window. Its upper positions hold bits left over from earlier transfers.
- R6: Word bit 5 is the standby control: 1 drives standby high (low-current mode) and 0 means active operation.
- R7: A committed word with bit 7 or bit 6 set raises the error flag. The flag stays set until reset, and the standby bit and tuning field of that word are still applied.
- R8: Serial clock edges that occur while the enable is low shift nothing. A later commit with no clocks in between reproduces the previous word.
- R9: Between commits the tuning code and standby outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is captured on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Transfer enable; its falling edge commits the window |
| tune_code | output | 5 | Active tuning state code |
| standby | output | 1 | Active standby control, 1 = low-current mode |
| rsv_err | output | 1 | Sticky flag for a committed word with reserved bits set |

## Verification
The assertions take for granted that each serial line holds a level for at least two system clocks, so that every edge survives synchronization. They also assume that a rising serial clock edge and a falling enable never arrive in the same synchronized cycle. The bench drives the lines away from the system clock edge and holds every serial clock phase for four system cycles. It also leaves four idle cycles between the last bit and the enable edges, so the stimulus always stays within these limits.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   localparam int DFLT_CODE_W = 5;
   localparam int DFLT_RSV_W  = 2;
   localparam int DFLT_SYNC   = 2;

   typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} tcap_edge_e;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_chk_stages
      $error("tcap_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_chk_w
      $error("tcap_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge
   import tcap_pkg::*;
#(
   parameter tcap_edge_e DIR = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   if (DIR == EDGE_RISE) begin : g_rise
      assign pulse = lvl & ~prev;
   end else begin : g_fall
      assign pulse = ~lvl & prev;
   end

   // R2: an edge pulse lasts exactly one system cycle
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/tcap_window.sv
module tcap_window #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [WORD_W-1:0] win
);
   if (WORD_W < 2) begin : g_chk_word
      $error("tcap_window: WORD_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        win <= '0;
      else if (shift_en) win <= {win[WORD_W-2:0], din};
   end

   // R2: newest bit enters at the low end, older bits move up
   a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (win[0] == $past(din)) && (win[WORD_W-1:1] == $past(win[WORD_W-2:0])));

   // R8: without a qualified clock edge the window keeps its contents
   a_r8_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(win));
endmodule

// File: rtl/tunecap_serial_slave.sv
module tunecap_serial_slave
   import tcap_pkg::*;
#(
   parameter int CODE_W      = DFLT_CODE_W,
   parameter int RSV_W       = DFLT_RSV_W,
   parameter int SYNC_STAGES = DFLT_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_en,
   output logic [CODE_W-1:0] tune_code,
   output logic              standby,
   output logic              rsv_err
);
   localparam int WORD_W   = RSV_W + 1 + CODE_W;
   localparam int STBY_BIT = CODE_W;

   if (CODE_W < 1) begin : g_chk_code
      $error("tunecap_serial_slave: CODE_W must be positive");
   end
   if (RSV_W < 0) begin : g_chk_rsv
      $error("tunecap_serial_slave: RSV_W must not be negative");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("tunecap_serial_slave: SYNC_STAGES must be at least 2");
   end

   logic [2:0]        s_bus;
   logic              s_clk, s_dat, s_en;
   logic              clk_rise, en_fall;
   logic              shift_en, commit;
   logic [WORD_W-1:0] window;

   tcap_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_dat, ser_en}),
      .q     (s_bus)
   );
   assign {s_clk, s_dat, s_en} = s_bus;

   tcap_edge #(.DIR(EDGE_RISE)) u_clk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (s_clk),
      .pulse (clk_rise)
   );

   tcap_edge #(.DIR(EDGE_FALL)) u_en_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (s_en),
      .pulse (en_fall)
   );

   assign shift_en = clk_rise & s_en;
   assign commit   = en_fall;

   tcap_window #(.WORD_W(WORD_W)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (s_dat),
      .win      (window)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tune_code <= '0;
         standby   <= 1'b0;
      end else if (commit) begin
         tune_code <= window[CODE_W-1:0];
         standby   <= window[STBY_BIT];
      end
   end

   if (RSV_W > 0) begin : g_rsv_check
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 rsv_err <= 1'b0;
         else if (commit && (|window[WORD_W-1 -: RSV_W])) rsv_err <= 1'b1;
      end

      // R7: a committed word with a reserved bit set raises the flag
      a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
         (commit && (|window[WORD_W-1 -: RSV_W])) |=> rsv_err);
   end else begin : g_no_rsv
      assign rsv_err = 1'b0;
   end

   // R7: once raised, the flag stays until reset
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_err |=> rsv_err);

   // R9: outputs move only on a commit
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(tune_code) && $stable(standby)));

   // R6: the standby output follows the committed window bit
   a_r6_standby: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (standby == $past(window[STBY_BIT])));

   // R2: the tuning field follows the low bits of the committed window
   a_r2_code: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (tune_code == $past(window[CODE_W-1:0])));
endmodule

// File: tb/tunecap_serial_slave_bench.sv
module tunecap_serial_slave_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic       ser_en = 1'b0;
   logic [4:0] tune_code;
   logic       standby;
   logic       rsv_err;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   tunecap_serial_slave u_tunecap_serial_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk   (ser_clk),
      .ser_dat   (ser_dat),
      .ser_en    (ser_en),
      .tune_code (tune_code),
      .standby   (standby),
      .rsv_err   (rsv_err)
   );

   // entry: {bit count, bits sent msb first, expected code, standby, error}
   localparam int NV = 8;
   localparam logic [22:0] VEC [NV] = '{
      {4'd8,  12'h013, 5'h13, 1'b0, 1'b0},   // R2 plain word
      {4'd8,  12'h02A, 5'h0A, 1'b1, 1'b0},   // R6 standby set
      {4'd8,  12'h01F, 5'h1F, 1'b0, 1'b0},   // R2 maximum code
      {4'd12, 12'hF05, 5'h05, 1'b0, 1'b0},   // R4 last eight kept
      {4'd3,  12'h006, 5'h0E, 1'b1, 1'b0},   // R5 short word, window 0x2E
      {4'd8,  12'h000, 5'h00, 1'b0, 1'b0},   // R2 minimum code
      {4'd8,  12'h09B, 5'h1B, 1'b0, 1'b1},   // R7 reserved bit set
      {4'd8,  12'h004, 5'h04, 1'b0, 1'b1}    // R7 flag stays
   };

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got code/stby/err %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      ser_dat = b;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [6:0] prev;
      wait_clk(5);
      check("R1 reset", {tune_code, standby, rsv_err}, 7'h00);
      rst_n = 1'b1;
      wait_clk(4);
      prev = 7'h00;

      for (int v = 0; v < NV; v++) begin
         int n;
         n = int'(VEC[v][22:19]);
         ser_en = 1'b1;
         wait_clk(4);
         for (int b = n - 1; b >= 0; b--) send_bit(VEC[v][7 + b]);
         wait_clk(4);
         check("R3 hold before commit", {tune_code, standby, rsv_err}, prev);
         ser_en = 1'b0;
         wait_clk(8);
         check($sformatf("R2/R4/R5/R6/R7 vector %0d", v),
               {tune_code, standby, rsv_err}, VEC[v][6:0]);
         prev = VEC[v][6:0];
      end

      // R8: clocks with enable low are ignored; empty commit repeats word 0x04
      for (int k = 0; k < 3; k++) send_bit(1'b1);
      wait_clk(4);
      check("R8 no shift while disabled", {tune_code, standby, rsv_err}, prev);
      ser_en = 1'b1;
      wait_clk(8);
      ser_en = 1'b0;
      wait_clk(8);
      check("R8 recommit unchanged window", {tune_code, standby, rsv_err}, 7'b00100_0_1);

      // R1: reset mid-run clears outputs and the sticky flag
      rst_n = 1'b0;
      wait_clk(3);
      check("R1 reset clears", {tune_code, standby, rsv_err}, 7'h00);
      rst_n = 1'b1;
      wait_clk(4);
      // R1: window cleared, so 2 bits '11' commit as 0x03
      ser_en = 1'b1;
      wait_clk(4);
      send_bit(1'b1);
      send_bit(1'b1);
      wait_clk(4);
      ser_en = 1'b0;
      wait_clk(8);
      check("R1 window cleared", {tune_code, standby, rsv_err}, 7'b00011_0_0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule